// File: doc/BRIEF.md
# Buffered SPI Master with Direction Modes

This block is the master side of a serial peripheral link. It moves fixed-width words (8 bits by default) with the most significant bit first. A host writes the word to send into a one-entry transmit holding register and takes each received word from a one-entry receive holding register. Three flags tell the host when to act: transmit-empty, receive-full and overrun. The serial clock runs at a fixed fraction of the system clock, set by a parameter.

Software picks one of three transfer directions. In full-duplex, a word goes out while a word comes in. In transmit-only, received bits are thrown away. In receive-only, the clock runs on its own for as long as the block is enabled. Clock polarity and phase can be chosen. A frame-pulse option replaces the level-held chip select with a one-clock-period marker before each frame. In that option polarity and phase are fixed, so the idle clock is low, data changes on the rising edge and is sampled on the falling edge.

Top module: `spim_master`

## Requirements
- R1: After reset, with frame-pulse off and polarity 0: `tbe`=1, `rbne`=0, `ovr`=0, `sck`=0, `nss`=1, `mosi`=0.
- R2: Each frame shifts the transmitted word out on `mosi` MSB first and shifts `miso` into a word MSB first. At the end of the frame the received word goes to `rd_data` and `rbne` is set. A one-cycle `rd_en` pulse clears `rbne`.
- R3: With frame-pulse off, `sck` idles at `cpol`. With `cpha`=0, data is sampled on the first edge of each bit. With `cpha`=1, it is sampled on the second edge. Each `sck` half period is `HALF_DIV` clocks.
- R4: `tbe` is 1 while the transmit holding register is empty. A write clears it, and it returns to 1 when the word is taken into the shifter. A write while `tbe`=0 is ignored, and the stored word stays the same.
- R5: In full-duplex (`dir_sel`=0; code 3 behaves the same), a frame starts only when a word is waiting. A word written before the current frame ends follows with no gap, and `nss` stays low across the burst. With no word waiting, `sck` stays idle.
- R6: In receive-only (`dir_sel`=2), frames follow one another for as long as `enable` is 1, with no writes, and `mosi` sends zeros.
- R7: If a frame finishes while `rbne`=1, `ovr` is set and `rd_data` keeps the older word. A `clr_ovr` pulse clears `ovr` only when `rbne`=0.
- R8: In transmit-only (`dir_sel`=1), received frames never set `rbne` or `ovr`.
- R9: With `frame_mode`=1, `cpol` and `cpha` have no effect: `sck` idles low, data is sampled on the falling edge, and `nss` is high for one `sck` period just before the first bit of each frame and low otherwise.
- R10: Clearing `enable` during a frame lets that frame finish. `sck` then returns to its idle level and the flags are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows frames to start |
| dir_sel | input | 2 | 0 full-duplex, 1 transmit-only, 2 receive-only, 3 as 0 |
| cpol | input | 1 | Idle clock level (ignored in frame-pulse option) |
| cpha | input | 1 | 0 sample on first edge, 1 on second (ignored in frame-pulse option) |
| frame_mode | input | 1 | Selects frame-pulse marker on `nss` |
| wr_en | input | 1 | Write strobe for the transmit register |
| wr_data | input | DW | Word to transmit |
| rd_en | input | 1 | Read strobe; clears `rbne` |
| clr_ovr | input | 1 | Clears `ovr` when `rbne` is 0 |
| rd_data | output | DW | Received word |
| tbe | output | 1 | Transmit register empty |
| rbne | output | 1 | Receive register holds an unread word |
| ovr | output | 1 | A frame was lost because the receive register was full |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| nss | output | 1 | Chip select, or frame marker in frame-pulse option |

## Verification
The assertions assume that the host raises `rd_en` only as a single-cycle strobe, and that it changes polarity, phase, direction and frame-pulse selection only while no frame is in progress. The bench sets a configuration, lets the engine go idle, and only then resets its own frame counters. It pulses `rd_en` for one cycle per word seen with `rbne` high, and it writes only when it sees `tbe` high. The one exception is the ignored-write case, which deliberately writes into a full register. Its model of the serial partner changes `miso` right after each sampling edge, so the data stays stable across the edge where the master samples it.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    DIR_FULL = 2'd0,
    DIR_TXO  = 2'd1,
    DIR_RXO  = 2'd2,
    DIR_RSV  = 2'd3
  } dir_e;
endpackage

// File: rtl/spim_tick.sv
module spim_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)    cnt_q <= '0;
    else if (cnt_q == TOP) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == TOP);
endmodule

// File: rtl/spim_bufs.sv
module spim_bufs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          clr_ovr,
  input  logic          tx_pop,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_word,
  output logic [DW-1:0] tx_word,
  output logic [DW-1:0] rd_data,
  output logic          tbe,
  output logic          rbne,
  output logic          ovr
);
  logic          tx_full_q;
  logic [DW-1:0] tx_q;
  logic [DW-1:0] rx_q;
  logic          rbne_q;
  logic          ovr_q;

  // transmit holding register: a write into a full register is dropped
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_full_q <= 1'b0;
      tx_q      <= '0;
    end else if (wr_en && !tx_full_q) begin
      tx_full_q <= 1'b1;
      tx_q      <= wr_data;
    end else if (tx_pop) begin
      tx_full_q <= 1'b0;
    end
  end

  // receive holding register: the older word wins on overrun
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q   <= '0;
      rbne_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (rd_en) rbne_q <= 1'b0;
      if (rx_push && !rbne_q) begin
        rx_q   <= rx_word;
        rbne_q <= 1'b1;
      end
      if (rx_push && rbne_q)        ovr_q <= 1'b1;
      else if (clr_ovr && !rbne_q)  ovr_q <= 1'b0;
    end
  end

  assign tx_word = tx_q;
  assign rd_data = rx_q;
  assign tbe     = !tx_full_q;
  assign rbne    = rbne_q;
  assign ovr     = ovr_q;

  assert_read_clears_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en && rbne_q |=> !rbne_q);

  assert_unread_word_held_R7: assert property (@(posedge clk) disable iff (rst)
    rbne_q && !rd_en |=> $stable(rx_q));

  assert_overrun_needs_full_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_q) |-> $past(rbne_q));
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  dir_e          dir_sel,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          fmode,
  input  logic          tick,
  input  logic          tbe,
  input  logic [DW-1:0] tx_word,
  input  logic          miso,
  output logic          active,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [DW-1:0] rx_word,
  output logic          sck,
  output logic          mosi,
  output logic          nss
);
  localparam int HW = $clog2(2 * DW + 3);
  localparam logic [HW-1:0] HDR_HALVES = HW'(2);
  localparam logic [HW-1:0] LAST_HALF  = HW'(2 * DW - 1);

  logic          act_q;
  logic [HW-1:0] hcnt_q;
  dir_e          dir_q;
  logic          cpha_q;
  logic          fm_q;
  logic [DW-1:0] tx_sh;
  logic [DW-1:0] rx_sh;
  logic          mosi_q;
  logic          sck_q;
  logic          nss_q;

  logic [HW-1:0] off, dpos, hcnt_n;
  logic          in_data, lead_e, trail_e, last_e, smp, shf;
  logic          start_ok, load, new_cpha, new_cpol;
  logic          act_n, fm_n, nss_n, sck_n;
  logic [DW-1:0] load_word;

  // position of the current half period inside the data part of the frame
  always_comb begin
    off     = fm_q ? HDR_HALVES : '0;
    in_data = hcnt_q >= off;
    dpos    = hcnt_q - off;
    lead_e  = tick && act_q && in_data && !dpos[0];
    trail_e = tick && act_q && in_data &&  dpos[0];
    last_e  = trail_e && (dpos == LAST_HALF);
    smp     = cpha_q ? trail_e : lead_e;
    shf     = cpha_q ? lead_e  : (trail_e && !last_e);
  end

  // frame start policy: receive-only free-runs, the others need a word
  always_comb begin
    start_ok  = enable && ((dir_sel == DIR_RXO) || !tbe);
    load      = start_ok && (!act_q || last_e);
    new_cpha  = fmode | cpha;
    new_cpol  = cpol & ~fmode;
    load_word = (dir_sel == DIR_RXO) ? '0 : tx_word;
  end

  always_comb begin
    act_n  = load ? 1'b1 : (last_e ? 1'b0 : act_q);
    hcnt_n = (load || last_e) ? '0 : ((act_q && tick) ? hcnt_q + 1'b1 : hcnt_q);
    fm_n   = (load || !act_q) ? fmode : fm_q;
    nss_n  = fm_n ? (act_n && (hcnt_n < HDR_HALVES)) : !act_n;
    if (act_q && tick) sck_n = ~sck_q;
    else if (!act_q)   sck_n = new_cpol;
    else               sck_n = sck_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      hcnt_q <= '0;
      dir_q  <= DIR_FULL;
      cpha_q <= 1'b0;
      fm_q   <= 1'b0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      mosi_q <= 1'b0;
      sck_q  <= 1'b0;
      nss_q  <= 1'b1;
    end else begin
      act_q  <= act_n;
      hcnt_q <= hcnt_n;
      fm_q   <= fm_n;
      nss_q  <= nss_n;
      sck_q  <= sck_n;
      if (load) begin
        dir_q  <= dir_sel;
        cpha_q <= new_cpha;
        rx_sh  <= '0;
        if (new_cpha) begin
          tx_sh <= load_word;
        end else begin
          tx_sh  <= load_word << 1;
          mosi_q <= load_word[DW-1];
        end
      end else begin
        if (smp) rx_sh <= {rx_sh[DW-2:0], miso};
        if (shf) begin
          mosi_q <= tx_sh[DW-1];
          tx_sh  <= tx_sh << 1;
        end
      end
    end
  end

  assign active  = act_q;
  assign tx_pop  = load && (dir_sel != DIR_RXO);
  assign rx_push = last_e && (dir_q != DIR_TXO);
  assign rx_word = cpha_q ? {rx_sh[DW-2:0], miso} : rx_sh;
  assign sck     = sck_q;
  assign mosi    = mosi_q;
  assign nss     = nss_q;

  assert_pop_needs_word_R4: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> !tbe);

  assert_sck_paced_by_tick_R3: assert property (@(posedge clk) disable iff (rst)
    act_q && !tick |=> $stable(sck_q));

  assert_txonly_no_push_R8: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> (dir_q != DIR_TXO));
endmodule

// File: rtl/spim_master.sv
module spim_master
  import spim_pkg::*;
#(
  parameter int DW       = 8,
  parameter int HALF_DIV = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [1:0]    dir_sel,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          frame_mode,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          clr_ovr,
  output logic [DW-1:0] rd_data,
  output logic          tbe,
  output logic          rbne,
  output logic          ovr,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic          nss
);
  logic          active, tick, tx_pop, rx_push;
  logic [DW-1:0] tx_word, rx_word;

  spim_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (active),
    .tick(tick)
  );

  spim_bufs #(.DW(DW)) u_bufs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .rd_en  (rd_en),
    .clr_ovr(clr_ovr),
    .tx_pop (tx_pop),
    .rx_push(rx_push),
    .rx_word(rx_word),
    .tx_word(tx_word),
    .rd_data(rd_data),
    .tbe    (tbe),
    .rbne   (rbne),
    .ovr    (ovr)
  );

  spim_engine #(.DW(DW)) u_engine (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .dir_sel(dir_e'(dir_sel)),
    .cpol   (cpol),
    .cpha   (cpha),
    .fmode  (frame_mode),
    .tick   (tick),
    .tbe    (tbe),
    .tx_word(tx_word),
    .miso   (miso),
    .active (active),
    .tx_pop (tx_pop),
    .rx_push(rx_push),
    .rx_word(rx_word),
    .sck    (sck),
    .mosi   (mosi),
    .nss    (nss)
  );
endmodule

// File: tb/tb_spim_master.sv
module tb_spim_master;
  localparam int HD = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic [1:0] dir_sel = 2'd0;
  logic       cpol = 1'b0, cpha = 1'b0, frame_mode = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, clr_ovr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       tbe, rbne, ovr, sck, mosi, nss;
  logic       miso = 1'b0;

  spim_master #(.DW(8), .HALF_DIV(HD)) dut (
    .clk(clk), .rst(rst), .enable(enable), .dir_sel(dir_sel),
    .cpol(cpol), .cpha(cpha), .frame_mode(frame_mode),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .clr_ovr(clr_ovr),
    .rd_data(rd_data), .tbe(tbe), .rbne(rbne), .ovr(ovr),
    .miso(miso), .sck(sck), .mosi(mosi), .nss(nss)
  );

  always #4 clk = ~clk;

  int  total = 0, fails = 0, cycles = 0;
  bit  done = 0;
  int  nsamp = 0, nss_rises = 0;
  logic [7:0] mon_byte = '0;
  logic prev_sck = 1'b0, prev_nss = 1'b1;
  logic [7:0] seed_tx = 8'h00, seed_rx = 8'h00;

  function automatic logic [7:0] f_tx(input int i);
    return 8'(i) ^ seed_tx;
  endfunction
  function automatic logic [7:0] f_rx(input int i);
    return 8'(i * 97 + int'(seed_rx));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        finish_run();
      end
    end
  end

  // serial partner: checks outgoing words, supplies incoming bits (R2, R3, R9)
  always @(negedge clk) begin
    logic smp_edge;
    logic [7:0] w;
    if (sck !== prev_sck && prev_nss == 1'b0) begin
      if (frame_mode) smp_edge = (sck == 1'b0);
      else if (cpha)  smp_edge = (sck == cpol);
      else            smp_edge = (sck != cpol);
      if (smp_edge) begin
        mon_byte = {mon_byte[6:0], mosi};
        nsamp++;
        if (nsamp % 8 == 0) begin
          w = (dir_sel == 2'd2) ? 8'h00 : f_tx(nsamp / 8 - 1);
          check(mon_byte == w, (dir_sel == 2'd2) ? "R6 mosi zeros" : "R2 mosi word",
                mon_byte, w);
        end
      end
    end
    if (prev_nss == 1'b0 && nss == 1'b1) nss_rises++;
    prev_sck = sck;
    prev_nss = nss;
    w = f_rx(nsamp / 8);
    miso = w[7 - (nsamp % 8)];
  end

  task automatic set_cfg(input logic [1:0] d, input logic p, input logic h,
                         input logic f, input logic [7:0] st, input logic [7:0] sr);
    @(negedge clk);
    enable = 0; dir_sel = d; cpol = p; cpha = h; frame_mode = f;
    seed_tx = st; seed_rx = sr;
    repeat (4) @(negedge clk);
    nsamp = 0; nss_rises = 0;
    @(negedge clk);
  endtask

  // burst in full-duplex or transmit-only; pre words already written
  task automatic run_burst(input int n, input int pre);
    int wtx = pre, rdn = 0, guard = 0;
    enable = 1;
    while (guard < n * 64 + 400 &&
           !(nsamp == 8 * n && (dir_sel == 2'd1 || rdn == n))) begin
      @(negedge clk);
      guard++;
      wr_en = 0; rd_en = 0;
      if (tbe && wtx < n) begin
        wr_en = 1; wr_data = f_tx(wtx); wtx++;
      end
      if (rbne) begin
        check(rd_data == f_rx(rdn), "R2 received word", rd_data, f_rx(rdn));
        rd_en = 1; rdn++;
      end
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    repeat (4 * HD + 4) @(negedge clk);
    check(nsamp == 8 * n, "R5 frames sent", nsamp, 8 * n);
    // no word waiting: clock must stay idle (R5)
    repeat (60) @(negedge clk);
    check(nsamp == 8 * n, "R5 no start without data", nsamp, 8 * n);
    check(sck == (frame_mode ? 1'b0 : cpol), "R3 idle level", sck, frame_mode ? 0 : cpol);
    if (frame_mode) begin
      check(nss_rises == n, "R9 marker per frame", nss_rises, n);
      check(nss == 1'b0, "R9 marker low idle", nss, 0);
    end else begin
      check(nss_rises == 1, "R5 no gap in burst", nss_rises, 1);
      check(nss == 1'b1, "R5 select high idle", nss, 1);
    end
    if (dir_sel == 2'd1) begin
      check(rbne == 1'b0, "R8 no receive flag", rbne, 0);
      check(ovr == 1'b0, "R8 no overrun", ovr, 0);
    end else begin
      check(rdn == n, "R2 words read", rdn, n);
      check(ovr == 1'b0, "R7 no overrun when read", ovr, 0);
    end
    enable = 0;
  endtask

  // receive-only: free-running, stopped mid frame n (R6, R10)
  task automatic run_rx(input int n);
    int rdn = 0;
    enable = 1;
    for (int g = 0; g < n * 80 + 400; g++) begin
      @(negedge clk);
      rd_en = 0;
      if (rbne) begin
        check(rd_data == f_rx(rdn), "R6 received word", rd_data, f_rx(rdn));
        rd_en = 1; rdn++;
      end
      if (enable && nsamp >= 8 * n + 3) enable = 0;
      if (!enable && g > n * 80) break;
    end
    @(negedge clk);
    rd_en = 0;
    check(nsamp == 8 * (n + 1), "R10 frame finished after disable", nsamp, 8 * (n + 1));
    check(rdn == n + 1, "R6 words without writes", rdn, n + 1);
    check(sck == (frame_mode ? 1'b0 : cpol), "R10 idle after disable", sck,
          frame_mode ? 0 : cpol);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(tbe == 1'b1, "R1 tbe", tbe, 1);
    check(rbne == 1'b0, "R1 rbne", rbne, 0);
    check(ovr == 1'b0, "R1 ovr", ovr, 0);
    check(sck == 1'b0, "R1 sck", sck, 0);
    check(nss == 1'b1, "R1 nss", nss, 1);
    check(mosi == 1'b0, "R1 mosi", mosi, 0);

    // full-duplex, all clock modes, every byte value; first word tests ignored write (R4)
    for (int m = 0; m < 5; m++) begin
      set_cfg((m == 4) ? 2'd3 : 2'd0, m[0], m[1], m == 4, 8'(m * 51), 8'(m * 13 + 7));
      if (m == 0) begin
        wr_en = 1; wr_data = f_tx(0);
        @(negedge clk);
        check(tbe == 1'b0, "R4 write clears tbe", tbe, 0);
        wr_data = ~f_tx(0);
        @(negedge clk);
        wr_en = 0;
        check(tbe == 1'b0, "R4 still full", tbe, 0);
        run_burst(256, 1);
      end else begin
        run_burst(256, 0);
      end
    end

    // frame-pulse with every polarity/phase setting: settings ignored (R9)
    for (int m = 0; m < 4; m++) begin
      set_cfg(2'd0, m[0], m[1], 1'b1, 8'(m * 7 + 3), 8'(m * 29 + 1));
      check(sck == 1'b0, "R9 idle low", sck, 0);
      run_burst(12, 0);
    end

    // transmit-only
    for (int m = 0; m < 5; m++) begin
      set_cfg(2'd1, m[0], m[1], m == 4, 8'(m * 17 + 9), 8'h33);
      run_burst(16, 0);
    end

    // receive-only with disable mid frame
    for (int m = 0; m < 5; m++) begin
      set_cfg(2'd2, m[0], m[1], m == 4, 8'h00, 8'(m * 41 + 5));
      run_rx(20);
    end

    // overrun: three frames, none read (R7, R10)
    set_cfg(2'd2, 1'b0, 1'b1, 1'b0, 8'h00, 8'h6C);
    enable = 1;
    for (int g = 0; g < 400; g++) begin
      @(negedge clk);
      if (nsamp >= 19) begin enable = 0; break; end
    end
    repeat (100) @(negedge clk);
    check(nsamp == 24, "R10 frames after disable", nsamp, 24);
    check(rbne == 1'b1, "R10 rbne kept", rbne, 1);
    check(ovr == 1'b1, "R7 overrun set", ovr, 1);
    check(rd_data == f_rx(0), "R7 older word kept", rd_data, f_rx(0));
    clr_ovr = 1;
    @(negedge clk);
    clr_ovr = 0;
    @(negedge clk);
    check(ovr == 1'b1, "R7 clear ignored while full", ovr, 1);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
    check(rbne == 1'b0, "R2 read clears rbne", rbne, 0);
    clr_ovr = 1;
    @(negedge clk);
    clr_ovr = 0;
    @(negedge clk);
    check(ovr == 1'b0, "R7 clear after read", ovr, 0);

    finish_run();
  end
endmodule